// File: doc/BRIEF.md
# Three-Channel Timer Host Register Interface

This block is the processor-facing register front end of a three-channel interval timer. A host talks to it over an 8-bit data bus with chip-select, read and write strobes and a 2-bit register address. Addresses 0 to 2 reach the three channels' count ports. Address 3 is the command register. The block turns command bytes into per-channel configuration (access width, mode, BCD flag). It assembles count values from one or two byte writes and hands each finished value to its counter core with a one-cycle load strobe. A hold line tells the core to pause while a two-byte count is half written.

On the read side, each channel can return its live count or a frozen snapshot. The snapshot is taken either by a per-channel latch command or by a read-back command that freezes several channels in one write. The read-back command can also freeze a status byte. That byte carries the output level, a pending-load flag and the programmed configuration. A frozen status byte is always returned before any frozen count bytes. The bus is synchronous: strobes are sampled on the rising clock edge, and read data is combinational from the current address.

Top module: `tmr_host_regs`

## Requirements
- R1: After reset every channel is configured for two-byte access, mode 0 and binary counting. The hold and load strobe outputs are low, and the pending-load flag is clear.
- R2: A write to address 3 with bits [7:6] = channel number (0..2) and bits [5:4] not equal to 00 sets that channel's configuration. Bits [5:4] give the access width, bits [3:1] the mode and bit 0 the BCD flag. The mode and BCD outputs show the new values from the next cycle.
- R3: With access width 01 (low byte only), a count write loads {8'h00, data}. The load strobe is high for the one cycle after the write.
- R4: With access width 10 (high byte only), a count write loads {data, 8'h00} with the same strobe timing.
- R5: With access width 11, the first count write raises hold and gives no strobe. The second write strobes {second, first} and drops hold. Channels sequence their writes independently.
- R6: A command with bits [5:4] = 00 freezes the addressed channel's count. Reads then return the frozen value until its last byte has been read. After that, reads follow the live count.
- R7: A count-latch request (latch command or read-back) for a channel whose count is already frozen has no effect.
- R8: Count reads return the low byte only for width 01 and the high byte only for width 10. For width 11 they alternate low, then high.
- R9: A read-back command (bits [7:6] = 11, bit 0 = 0) with bit 5 = 0 freezes the counts of every channel whose mask bit is set. Bit 1 selects channel 0, bit 2 channel 1 and bit 3 channel 2.
- R10: A read-back command with bit 4 = 0 freezes the status byte of each selected channel. The status byte is {output level, pending-load flag, width[1:0], mode[2:0], BCD}.
- R11: When both status and count are frozen, the first read returns the status byte. The following reads return the count bytes in the programmed order.
- R12: The pending-load flag is set when a complete count is strobed to the core, not on the first byte of a two-byte write. It clears when the core reports that it has taken the count.
- R13: Writing a channel's configuration discards its frozen count and status. It also restarts the byte sequencing of both writes and reads and releases hold.
- R14: Strobes with chip-select low have no effect on any channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_addr | input | 2 | 0..2 channel count port, 3 command register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cnt_ld_val | output | 48 | Count handed to each core, 16 bits per channel |
| cnt_ld_stb | output | 3 | One-cycle load strobe per channel |
| cnt_hold | output | 3 | Pause request while a two-byte count is half written |
| cnt_mode | output | 9 | Programmed mode, 3 bits per channel |
| cnt_bcd | output | 3 | Programmed BCD flag per channel |
| cnt_cur | input | 48 | Live count from each core, 16 bits per channel |
| cnt_out | input | 3 | Output level of each core |
| cnt_taken | input | 3 | Core reports that the strobed count has been taken |

## Verification
On every cycle, the assertions check four things: at most one channel decodes a given bus access, a frozen count never changes while it stays frozen, a load strobe never coexists with hold and always raises the pending-load flag, and a status read always releases the status snapshot before any count byte is consumed. The assertions cannot show that the right bytes appear in the right order. Only the bench scenarios show that: the byte order of each access width, the mask decoding of the read-back command over all seven channel combinations, a repeated latch request being ignored, and a configuration write flushing a half-finished write or a frozen value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int CFG_W  = 6;

  // access width field of a configuration command
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } chcfg_t;

  localparam logic [1:0] SEL_RB   = 2'b11;
  localparam logic [1:0] CTL_ADDR = 2'b11;
  localparam chcfg_t     CFG_RST  = '{acc: ACC_WORD, mode: 3'd0, bcd: 1'b0};

  // status snapshot layout: level, pending flag, then configuration
  function automatic logic [BYTE_W-1:0] sts_byte(input logic lvl, input logic pend,
                                                 input chcfg_t c);
    return {lvl, pend, c.acc, c.mode, c.bcd};
  endfunction

  // true when the next count read must deliver the upper byte
  function automatic logic rd_hi_byte(input acc_e acc, input logic ptr);
    return (acc == ACC_HI) || ((acc == ACC_WORD) && ptr);
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] v, input logic hi);
    return hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

  // full count value produced by the completing write
  function automatic logic [CNT_W-1:0] merge_load(input acc_e acc,
                                                  input logic [BYTE_W-1:0] lo_prev,
                                                  input logic [BYTE_W-1:0] d);
    case (acc)
      ACC_LO:  return {{BYTE_W{1'b0}}, d};
      ACC_HI:  return {d, {BYTE_W{1'b0}}};
      default: return {d, lo_prev};
    endcase
  endfunction

endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NCH-1:0]    cfg_wr,
  output logic [NCH-1:0]    latch_cmd,
  output logic [NCH-1:0]    rb_cnt,
  output logic [NCH-1:0]    rb_sts,
  output logic [NCH-1:0]    cnt_wr,
  output logic [NCH-1:0]    rd_hit,
  output chcfg_t            cfg_val
);

  logic wr_ev, rd_ev, ctl_hit, rb_hit;

  // a cycle with both strobes is treated as no access
  assign wr_ev   = cs & wr & ~rd;
  assign rd_ev   = cs & rd & ~wr;
  assign ctl_hit = wr_ev && (addr == CTL_ADDR);
  assign rb_hit  = ctl_hit && (wdata[7:6] == SEL_RB) && !wdata[0];

  always_comb begin
    cfg_val.acc  = acc_e'(wdata[5:4]);
    cfg_val.mode = wdata[3:1];
    cfg_val.bcd  = wdata[0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [1:0] CH_ID = 2'(i);
    logic sel_me;
    assign sel_me       = ctl_hit && (wdata[7:6] == CH_ID);
    assign cfg_wr[i]    = sel_me && (wdata[5:4] != ACC_LATCH);
    assign latch_cmd[i] = sel_me && (wdata[5:4] == ACC_LATCH);
    assign rb_cnt[i]    = rb_hit && !wdata[5] && wdata[1+i];
    assign rb_sts[i]    = rb_hit && !wdata[4] && wdata[1+i];
    assign cnt_wr[i]    = wr_ev && (addr == CH_ID);
    assign rd_hit[i]    = rd_ev && (addr == CH_ID);
  end

  // R14
  ch_access_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cnt_wr | rd_hit | cfg_wr | latch_cmd));

  // R9
  rb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rb_cnt | rb_sts)) |-> ((cfg_wr == '0) && (latch_cmd == '0) && (cnt_wr == '0)));

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  chcfg_t            cfg_val,
  input  logic              latch_cmd,
  input  logic              rb_cnt,
  input  logic              rb_sts,
  input  logic              cnt_wr,
  input  logic              rd_hit,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cur_cnt,
  input  logic              out_lvl,
  input  logic              taken,
  output logic [CNT_W-1:0]  ld_val,
  output logic              ld_stb,
  output logic              hold,
  output chcfg_t            cfg,
  output logic [BYTE_W-1:0] rd_byte
);

  chcfg_t              cfg_q;
  logic [BYTE_W-1:0]   lo_q;
  logic                wptr_q, rptr_q;
  logic [CNT_W-1:0]    cnt_lat_q;
  logic                cnt_held_q;
  logic [BYTE_W-1:0]   sts_lat_q;
  logic                sts_held_q;
  logic                pend_q;
  logic [CNT_W-1:0]    ld_val_q;
  logic                ld_stb_q, hold_q;

  // named internal events
  logic is_word, lo_stage, load_done, snap_cnt, snap_sts, rd_sts, rd_cnt, rd_last;
  logic [CNT_W-1:0] cnt_src;

  assign is_word   = (cfg_q.acc == ACC_WORD);
  assign lo_stage  = cnt_wr && is_word && !wptr_q;
  assign load_done = cnt_wr && !(is_word && !wptr_q);
  assign snap_cnt  = (latch_cmd | rb_cnt) && !cnt_held_q;
  assign snap_sts  = rb_sts && !sts_held_q;
  assign rd_sts    = rd_hit && sts_held_q;
  assign rd_cnt    = rd_hit && !sts_held_q;
  assign rd_last   = rd_cnt && (!is_word || rptr_q);

  assign cnt_src = cnt_held_q ? cnt_lat_q : cur_cnt;
  assign rd_byte = sts_held_q ? sts_lat_q : pick_byte(cnt_src, rd_hi_byte(cfg_q.acc, rptr_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= CFG_RST;
      lo_q       <= '0;
      wptr_q     <= 1'b0;
      rptr_q     <= 1'b0;
      cnt_lat_q  <= '0;
      cnt_held_q <= 1'b0;
      sts_lat_q  <= '0;
      sts_held_q <= 1'b0;
      pend_q     <= 1'b0;
      ld_val_q   <= '0;
      ld_stb_q   <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      ld_stb_q <= load_done;
      if (load_done) ld_val_q <= merge_load(cfg_q.acc, lo_q, wdata);

      if (cfg_wr) begin
        cfg_q      <= cfg_val;
        wptr_q     <= 1'b0;
        rptr_q     <= 1'b0;
        cnt_held_q <= 1'b0;
        sts_held_q <= 1'b0;
        hold_q     <= 1'b0;
      end else begin
        if (lo_stage) begin
          lo_q   <= wdata;
          wptr_q <= 1'b1;
          hold_q <= 1'b1;
        end else if (load_done) begin
          wptr_q <= 1'b0;
          hold_q <= 1'b0;
        end

        if (snap_cnt) begin
          cnt_lat_q  <= cur_cnt;
          cnt_held_q <= 1'b1;
          rptr_q     <= 1'b0;
        end else if (rd_cnt) begin
          if (is_word) rptr_q <= ~rptr_q;
          if (rd_last) cnt_held_q <= 1'b0;
        end

        if (snap_sts) begin
          sts_lat_q  <= sts_byte(out_lvl, pend_q, cfg_q);
          sts_held_q <= 1'b1;
        end else if (rd_sts) begin
          sts_held_q <= 1'b0;
        end
      end

      if (load_done)  pend_q <= 1'b1;
      else if (taken) pend_q <= 1'b0;
    end
  end

  assign ld_val = ld_val_q;
  assign ld_stb = ld_stb_q;
  assign hold   = hold_q;
  assign cfg    = cfg_q;

  // R5
  stb_not_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb_q |-> !hold_q);

  // R12
  stb_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb_q |-> pend_q);

  // R12
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(taken));

  // R6
  latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_held_q && $past(cnt_held_q)) |-> $stable(cnt_lat_q));

  // R11
  sts_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && sts_held_q) |=> (!sts_held_q && $stable(cnt_held_q) && $stable(rptr_q)));

endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic [1:0]            addr,
  input  logic [NCH*BYTE_W-1:0] ch_bytes,
  output logic [BYTE_W-1:0]     rdata
);

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NCH; k++) begin
      if (addr == 2'(k)) rdata = ch_bytes[k*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/tmr_host_regs.sv
module tmr_host_regs
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_cs,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [1:0]           bus_addr,
  input  logic [BYTE_W-1:0]    bus_wdata,
  output logic [BYTE_W-1:0]    bus_rdata,
  output logic [NCH*CNT_W-1:0] cnt_ld_val,
  output logic [NCH-1:0]       cnt_ld_stb,
  output logic [NCH-1:0]       cnt_hold,
  output logic [NCH*3-1:0]     cnt_mode,
  output logic [NCH-1:0]       cnt_bcd,
  input  logic [NCH*CNT_W-1:0] cnt_cur,
  input  logic [NCH-1:0]       cnt_out,
  input  logic [NCH-1:0]       cnt_taken
);

  // channel numbers share the 2-bit address with the command register
  localparam int MODE_W = 3;

  logic [NCH-1:0] cfg_wr, latch_cmd, rb_cnt, rb_sts, cnt_wr, rd_hit;
  chcfg_t         cfg_val;
  logic [NCH*BYTE_W-1:0] ch_bytes;

  tmr_ctl_decode #(.NCH(NCH)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (bus_cs),
    .rd        (bus_rd),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .cfg_wr    (cfg_wr),
    .latch_cmd (latch_cmd),
    .rb_cnt    (rb_cnt),
    .rb_sts    (rb_sts),
    .cnt_wr    (cnt_wr),
    .rd_hit    (rd_hit),
    .cfg_val   (cfg_val)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    chcfg_t ch_cfg;
    tmr_chan_regs u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr[i]),
      .cfg_val   (cfg_val),
      .latch_cmd (latch_cmd[i]),
      .rb_cnt    (rb_cnt[i]),
      .rb_sts    (rb_sts[i]),
      .cnt_wr    (cnt_wr[i]),
      .rd_hit    (rd_hit[i]),
      .wdata     (bus_wdata),
      .cur_cnt   (cnt_cur[i*CNT_W +: CNT_W]),
      .out_lvl   (cnt_out[i]),
      .taken     (cnt_taken[i]),
      .ld_val    (cnt_ld_val[i*CNT_W +: CNT_W]),
      .ld_stb    (cnt_ld_stb[i]),
      .hold      (cnt_hold[i]),
      .cfg       (ch_cfg),
      .rd_byte   (ch_bytes[i*BYTE_W +: BYTE_W])
    );
    assign cnt_mode[i*MODE_W +: MODE_W] = ch_cfg.mode;
    assign cnt_bcd[i]                   = ch_cfg.bcd;
  end

  tmr_rd_mux #(.NCH(NCH)) u_mux (
    .addr     (bus_addr),
    .ch_bytes (ch_bytes),
    .rdata    (bus_rdata)
  );

endmodule

// File: tb/test_tmr_host_regs.sv
`timescale 1ns/1ps
module test_tmr_host_regs;

  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [NCH*16-1:0] cnt_ld_val, cnt_cur;
  logic [NCH-1:0] cnt_ld_stb, cnt_hold, cnt_bcd, cnt_taken;
  logic [NCH-1:0] cnt_out = '0;
  logic [NCH*3-1:0] cnt_mode;
  logic [NCH-1:0] tick = '0;
  logic [15:0] stub [NCH];
  logic [15:0] exp_cnt [NCH];
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  tmr_host_regs #(.NCH(NCH)) i_tmr_host_regs (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_ld_val(cnt_ld_val), .cnt_ld_stb(cnt_ld_stb), .cnt_hold(cnt_hold),
    .cnt_mode(cnt_mode), .cnt_bcd(cnt_bcd), .cnt_cur(cnt_cur), .cnt_out(cnt_out),
    .cnt_taken(cnt_taken)
  );

  // down-counter stub standing in for the counter cores
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCH; k++) stub[k] <= '0;
      cnt_taken <= '0;
    end else begin
      for (int k = 0; k < NCH; k++) begin
        cnt_taken[k] <= cnt_ld_stb[k];
        if (cnt_ld_stb[k]) stub[k] <= cnt_ld_val[k*16 +: 16];
        else if (tick[k] && !cnt_hold[k]) stub[k] <= stub[k] - 16'd1;
      end
    end
  end
  always_comb for (int k = 0; k < NCH; k++) cnt_cur[k*16 +: 16] = stub[k];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    bus_cs = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(input logic [1:0] a, output logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    bus_cs = sel; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_cs = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_ch(input int ch, input int n);
    @(negedge clk);
    tick[ch] = 1'b1;
    repeat (n) @(negedge clk);
    tick[ch] = 1'b0;
    exp_cnt[ch] = exp_cnt[ch] - 16'(n);
  endtask

  task automatic tick_all();
    @(negedge clk);
    tick = '1;
    @(negedge clk);
    tick = '0;
    for (int k = 0; k < NCH; k++) exp_cnt[k] = exp_cnt[k] - 16'd1;
  endtask

  task automatic load2(input int ch, input logic [7:0] lo, input logic [7:0] hi);
    bw(2'(ch), lo);
    bw(2'(ch), hi);
    idle(2);
    exp_cnt[ch] = {hi, lo};
  endtask

  function automatic logic [7:0] cw(input int ch, input logic [1:0] acc,
                                    input logic [2:0] mode, input logic bcd);
    return {2'(ch), acc, mode, bcd};
  endfunction

  function automatic logic [7:0] rbw(input logic no_cnt, input logic no_sts,
                                     input logic [2:0] mask);
    return {2'b11, no_cnt, no_sts, mask, 1'b0};
  endfunction

  initial begin
    logic [7:0] b0, b1;
    logic [7:0] pats [4];
    logic [15:0] pre [NCH];
    pats[0] = 8'h00; pats[1] = 8'h5A; pats[2] = 8'hA5; pats[3] = 8'hFF;
    for (int k = 0; k < NCH; k++) exp_cnt[k] = '0;

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 hold", 16'(cnt_hold), 16'h0);
    chk("R1 ld_stb", 16'(cnt_ld_stb), 16'h0);
    chk("R1 mode", 16'(cnt_mode), 16'h0);
    chk("R1 bcd", 16'(cnt_bcd), 16'h0);
    br(2'd0, b0);
    chk("R1 live read", 16'(b0), 16'h0);
    bw(2'd3, rbw(1'b1, 1'b0, 3'b001));
    br(2'd0, b0);
    chk("R1 R10 reset status", 16'(b0), 16'h0030);

    // sweep: every channel, every access width, several data patterns
    for (int ch = 0; ch < NCH; ch++) begin
      for (int acc = 1; acc < 4; acc++) begin
        for (int p = 0; p < 4; p++) begin
          logic [7:0] d, d2;
          logic [2:0] md;
          d  = pats[p] ^ 8'(ch * 17);
          d2 = ~d ^ 8'(acc);
          md = 3'(ch + acc + p);
          bw(2'd3, cw(ch, 2'(acc), md, p[0]));
          chk("R2 mode out", 16'(cnt_mode[ch*3 +: 3]), 16'(md));
          chk("R2 bcd out", 16'(cnt_bcd[ch]), 16'(p[0]));
          if (acc == 1) begin
            bw(2'(ch), d);
            chk("R3 strobe", 16'(cnt_ld_stb), 16'(1 << ch));
            chk("R3 value", cnt_ld_val[ch*16 +: 16], {8'h00, d});
            idle(2);
            br(2'(ch), b0);
            chk("R8 low only", 16'(b0), 16'(d));
            br(2'(ch), b0);
            chk("R8 low only again", 16'(b0), 16'(d));
          end else if (acc == 2) begin
            bw(2'(ch), d);
            chk("R4 strobe", 16'(cnt_ld_stb), 16'(1 << ch));
            chk("R4 value", cnt_ld_val[ch*16 +: 16], {d, 8'h00});
            idle(2);
            br(2'(ch), b0);
            chk("R8 high only", 16'(b0), 16'(d));
          end else begin
            bw(2'(ch), d);
            chk("R5 hold after first", 16'(cnt_hold), 16'(1 << ch));
            chk("R5 no strobe after first", 16'(cnt_ld_stb), 16'h0);
            bw(2'(ch), d2);
            chk("R5 strobe", 16'(cnt_ld_stb), 16'(1 << ch));
            chk("R5 value", cnt_ld_val[ch*16 +: 16], {d2, d});
            chk("R5 hold released", 16'(cnt_hold), 16'h0);
            idle(2);
            br(2'(ch), b0);
            br(2'(ch), b1);
            chk("R8 low then high", {b1, b0}, {d2, d});
          end
        end
      end
    end

    // R5 interleaved two-byte writes on two channels
    bw(2'd3, cw(0, 2'b11, 3'd0, 1'b0));
    bw(2'd3, cw(1, 2'b11, 3'd0, 1'b0));
    bw(2'd0, 8'h11);
    bw(2'd1, 8'h22);
    chk("R5 both held", 16'(cnt_hold), 16'h3);
    bw(2'd0, 8'h33);
    chk("R5 interleave ch0", cnt_ld_val[15:0], 16'h3311);
    bw(2'd1, 8'h44);
    chk("R5 interleave ch1", cnt_ld_val[31:16], 16'h4422);
    idle(2);

    // R12 pending flag through read-back status on channel 1
    bw(2'd3, cw(1, 2'b11, 3'd2, 1'b0));
    bw(2'd1, 8'h34);
    bw(2'd3, rbw(1'b1, 1'b0, 3'b010));
    br(2'd1, b0);
    chk("R12 first byte leaves flag clear", 16'(b0), 16'h0034);
    bw(2'd1, 8'h12);
    bw(2'd3, rbw(1'b1, 1'b0, 3'b010));
    br(2'd1, b0);
    chk("R12 flag set on load", 16'(b0), 16'h0074);
    idle(2);
    bw(2'd3, rbw(1'b1, 1'b0, 3'b010));
    br(2'd1, b0);
    chk("R12 flag cleared when taken", 16'(b0), 16'h0034);
    exp_cnt[1] = 16'h1234;

    // R6 latch command on channel 2
    bw(2'd3, cw(2, 2'b11, 3'd0, 1'b0));
    load2(2, 8'h34, 8'h12);
    bw(2'd3, cw(2, 2'b00, 3'd0, 1'b0));
    tick_ch(2, 5);
    br(2'd2, b0); br(2'd2, b1);
    chk("R6 frozen value", {b1, b0}, 16'h1234);
    br(2'd2, b0); br(2'd2, b1);
    chk("R6 live after release", {b1, b0}, exp_cnt[2]);

    // R7 second latch request while frozen
    bw(2'd3, cw(2, 2'b00, 3'd0, 1'b0));
    tick_ch(2, 3);
    bw(2'd3, cw(2, 2'b00, 3'd0, 1'b0));
    bw(2'd3, rbw(1'b0, 1'b1, 3'b100));
    tick_ch(2, 1);
    br(2'd2, b0); br(2'd2, b1);
    chk("R7 repeat latch ignored", {b1, b0}, 16'h122F);
    br(2'd2, b0); br(2'd2, b1);
    chk("R7 live afterwards", {b1, b0}, exp_cnt[2]);

    // R13 configuration write flushes latch and byte sequencing
    bw(2'd3, cw(2, 2'b00, 3'd0, 1'b0));
    tick_ch(2, 2);
    bw(2'd3, cw(2, 2'b11, 3'd0, 1'b0));
    br(2'd2, b0); br(2'd2, b1);
    chk("R13 latch discarded", {b1, b0}, exp_cnt[2]);
    bw(2'd2, 8'h77);
    bw(2'd3, cw(2, 2'b11, 3'd0, 1'b0));
    chk("R13 hold released", 16'(cnt_hold), 16'h0);
    bw(2'd2, 8'h11);
    chk("R13 write restarts at low byte", 16'(cnt_ld_stb), 16'h0);
    bw(2'd2, 8'h22);
    chk("R13 new value", cnt_ld_val[47:32], 16'h2211);
    idle(2);
    exp_cnt[2] = 16'h2211;

    // R9 read-back count latch over every channel mask
    for (int ch = 0; ch < NCH; ch++) begin
      bw(2'd3, cw(ch, 2'b11, 3'd0, 1'b0));
      load2(ch, 8'(8'h40 + ch), 8'h08);
    end
    for (int m = 1; m < 8; m++) begin
      for (int k = 0; k < NCH; k++) pre[k] = exp_cnt[k];
      bw(2'd3, rbw(1'b0, 1'b1, 3'(m)));
      tick_all();
      for (int k = 0; k < NCH; k++) begin
        br(2'(k), b0); br(2'(k), b1);
        chk("R9 mask read", {b1, b0}, m[k] ? pre[k] : exp_cnt[k]);
      end
    end

    // R11 status and count both frozen on channel 1
    bw(2'd3, cw(1, 2'b11, 3'd3, 1'b0));
    load2(1, 8'hEF, 8'hBE);
    cnt_out[1] = 1'b1;
    bw(2'd3, rbw(1'b0, 1'b0, 3'b010));
    tick_ch(1, 2);
    br(2'd1, b0);
    chk("R11 R10 status first", 16'(b0), 16'h00B6);
    br(2'd1, b0); br(2'd1, b1);
    chk("R11 count after status", {b1, b0}, 16'hBEEF);
    br(2'd1, b0); br(2'd1, b1);
    chk("R11 live afterwards", {b1, b0}, exp_cnt[1]);
    cnt_out[1] = 1'b0;

    // R14 strobes without chip select
    bw(2'd0, 8'h99, 1'b0);
    chk("R14 no strobe", 16'(cnt_ld_stb), 16'h0);
    chk("R14 no hold", 16'(cnt_hold), 16'h0);
    bw(2'd3, cw(0, 2'b00, 3'd0, 1'b0), 1'b0);
    tick_ch(0, 1);
    br(2'd0, b0, 1'b0);
    br(2'd0, b0); br(2'd0, b1);
    chk("R14 no latch and no pointer step", {b1, b0}, exp_cnt[0]);
    bw(2'd3, cw(0, 2'b01, 3'd5, 1'b1), 1'b0);
    chk("R14 configuration unchanged", 16'(cnt_mode[2:0]), 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule